// File: doc/BRIEF.md
# Two-Channel Paged Configuration Register Bank

This block keeps the configuration of two identical datapath channels, called A and B, behind one synchronous register bus. Each channel has its own copy of every paged field. A global channel-select register decides which copies a bus write lands in: channel A alone, channel B alone, both at once, or neither. Reads of a paged register return the copy picked by the same select value.

Each channel has two paged fields. The first is a 3-bit interpolation mode code. The second is an input-format bit: 0 means twos complement and 1 means offset binary. Both channels drive these fields straight out on ports to their datapaths.

A read-only status register reports whether the selected channel holds an interpolation code that the datapath does not support. The bus has address, write data, write enable, read enable and a registered read-data output.

Top module: `dual_page_cfg`

## Requirements
- R1: While `rst` is high at a clock edge, the bank sets the following reset state. The channel select becomes 3 (both channels). Both channels get format bit 0 and mode code 0. `bus_rdata` becomes 0.
- R2: When the channel select is 1, a write to a paged register changes only channel A. Channel B keeps its value.
- R3: When the channel select is 2, a write to a paged register changes only channel B. Channel A keeps its value.
- R4: When the channel select is 3, one write to a paged register updates both channels on the same clock edge.
- R5: When the channel select is 0, writes to paged registers change nothing. Reads of a paged register or of the status register return 0.
- R6: The channel select sits in bits [1:0] of address 0x008. This register is not paged and can be written whatever its current value, including 0. Write bits [7:2] are dropped, and a read returns 0 in bits [7:2].
- R7: A read of a paged register returns the channel A copy when the select is 1 or 3, and the channel B copy when the select is 2.
- R8: Address 0x030 is read-only. Bit 0 reads 1 when the selected channel's mode code is not one of 0, 1, 3 or 4. All other bits read 0.
- R9: `bus_rdata` is updated on the clock edge where `bus_re` is high and holds its value while `bus_re` is low. A read in the same cycle as a write to that register returns the value from before the write.
- R10: The paged mode code is at address 0x112, bits [2:0]; other bits read 0. The paged format bit is at address 0x110, bit 7; other bits read 0. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, acts on the rising edge |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| a_fmt_offset | output | 1 | Channel A format: 1 = offset binary |
| a_interp_mode | output | 3 | Channel A interpolation mode code |
| b_fmt_offset | output | 1 | Channel B format: 1 = offset binary |
| b_interp_mode | output | 3 | Channel B interpolation mode code |

## Verification
Suppose a write is steered to the wrong copy, or a write is lost while the select is 0. The bad value appears on a channel's field ports one cycle after the offending write. It appears on `bus_rdata` one cycle after the next read with that channel selected. A wrong read selection, with channel B returned under select 3 or a non-zero value under select 0, can only be seen through the read path. So the bench reads back every paged register under every select value after it writes. A stale or unregistered read path shows up as `bus_rdata` changing in a cycle without `bus_re`, or as a same-cycle read that returns the newly written value.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int BUS_AW  = 12;
    localparam int BUS_DW  = 8;
    localparam int NUM_CH  = 2;
    localparam int MODE_W  = 3;
    localparam int FMT_BIT = 7;

    localparam int unsigned ADDR_PAGE = 32'h008;
    localparam int unsigned ADDR_STAT = 32'h030;
    localparam int unsigned ADDR_FMT  = 32'h110;
    localparam int unsigned ADDR_MODE = 32'h112;

    // bit 0 steers to channel A, bit 1 steers to channel B
    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_A    = 2'd1,
        PG_B    = 2'd2,
        PG_BOTH = 2'd3
    } page_e;

    typedef struct packed {
        logic              fmt_offset;
        logic [MODE_W-1:0] interp;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{fmt_offset: 1'b0, interp: '0};

    function automatic logic mode_supported(input logic [MODE_W-1:0] m);
        return (m == 3'd0) || (m == 3'd1) || (m == 3'd3) || (m == 3'd4);
    endfunction
endpackage

// File: rtl/page_decode.sv
module page_decode
    import cfgbank_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  page_e         page,
    output logic [CH-1:0] ch_en,
    output logic          rd_valid,
    output logic          rd_sel
);
    generate
        for (genvar i = 0; i < CH; i++) begin : g_en
            assign ch_en[i] = page[i];
        end
    endgenerate

    // with both channels selected, reads come from channel A
    assign rd_valid = (page != PG_NONE);
    assign rd_sel   = (page == PG_B);

    always_comb begin
        assert (!(rd_valid && rd_sel) || !ch_en[0]) // p_rd_from_steered_r7
            else $error("p_rd_from_steered_r7");
    end
endmodule

// File: rtl/chan_regs.sv
module chan_regs
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fmt,
    input  logic              wr_mode,
    input  logic              fmt_in,
    input  logic [MODE_W-1:0] mode_in,
    output chan_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else begin
            if (wr_fmt)  cfg.fmt_offset <= fmt_in;
            if (wr_mode) cfg.interp     <= mode_in;
        end
    end

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_fmt || wr_mode) |=> $stable(cfg));
endmodule

// File: rtl/dual_page_cfg.sv
module dual_page_cfg
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W = BUS_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              a_fmt_offset,
    output logic [MODE_W-1:0] a_interp_mode,
    output logic              b_fmt_offset,
    output logic [MODE_W-1:0] b_interp_mode
);
    localparam logic [ADDR_W-1:0] A_PAGE = ADDR_W'(ADDR_PAGE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(ADDR_FMT);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);

    page_e              page_q;
    logic [NUM_CH-1:0]  ch_en;
    logic               rd_valid;
    logic               rd_sel;
    chan_cfg_t          cfg [NUM_CH];
    chan_cfg_t          sel_cfg;
    logic [BUS_DW-1:0]  rd_next;
    logic               unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[FMT_BIT-1:MODE_W];

    // global channel select, never paged
    always_ff @(posedge clk) begin
        if (rst)                              page_q <= PG_BOTH;
        else if (bus_we && bus_addr == A_PAGE) page_q <= page_e'(bus_wdata[1:0]);
    end

    page_decode #(.CH(NUM_CH)) u_dec (
        .page     (page_q),
        .ch_en    (ch_en),
        .rd_valid (rd_valid),
        .rd_sel   (rd_sel)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            chan_regs u_regs (
                .clk     (clk),
                .rst     (rst),
                .wr_fmt  (bus_we && bus_addr == A_FMT  && ch_en[i]),
                .wr_mode (bus_we && bus_addr == A_MODE && ch_en[i]),
                .fmt_in  (bus_wdata[FMT_BIT]),
                .mode_in (bus_wdata[MODE_W-1:0]),
                .cfg     (cfg[i])
            );
        end
    endgenerate

    assign a_fmt_offset  = cfg[0].fmt_offset;
    assign a_interp_mode = cfg[0].interp;
    assign b_fmt_offset  = cfg[1].fmt_offset;
    assign b_interp_mode = cfg[1].interp;

    assign sel_cfg = rd_sel ? cfg[1] : cfg[0];

    always_comb begin
        rd_next = '0;
        unique case (bus_addr)
            A_PAGE: rd_next[1:0] = page_q;
            A_FMT:  rd_next[FMT_BIT] = rd_valid & sel_cfg.fmt_offset;
            A_MODE: rd_next[MODE_W-1:0] = rd_valid ? sel_cfg.interp : '0;
            A_STAT: rd_next[0] = rd_valid & !mode_supported(sel_cfg.interp);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end

    p_reset_page_r1: assert property (@(posedge clk)
        rst |=> (page_q == PG_BOTH && bus_rdata == '0));

    p_a_only_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_MODE && page_q == PG_A) |=> $stable(b_interp_mode));

    p_b_only_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_MODE && page_q == PG_B) |=> $stable(a_interp_mode));

    p_both_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_MODE && page_q == PG_BOTH) |=>
        (a_interp_mode == $past(bus_wdata[MODE_W-1:0]) &&
         b_interp_mode == $past(bus_wdata[MODE_W-1:0])));

    p_none_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && page_q == PG_NONE && bus_addr != A_PAGE) |=>
        ($stable(a_interp_mode) && $stable(b_interp_mode) &&
         $stable(a_fmt_offset) && $stable(b_fmt_offset)));

    p_stat_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_STAT) |=> (bus_rdata[BUS_DW-1:1] == '0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/tb_dual_page_cfg.sv
module tb_dual_page_cfg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        a_fmt_offset, b_fmt_offset;
    logic [2:0]  a_interp_mode, b_interp_mode;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dual_page_cfg dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .a_fmt_offset(a_fmt_offset), .a_interp_mode(a_interp_mode),
        .b_fmt_offset(b_fmt_offset), .b_interp_mode(b_interp_mode)
    );

    // entry: {is_read, req, addr, data, expected}
    localparam int N = 32;
    localparam logic [32:0] TBL [N] = '{
        {1'b1, 4'd6,  12'h008, 8'h00, 8'h03}, // R6 default select reads 3
        {1'b0, 4'd4,  12'h112, 8'h03, 8'h00}, // R4 write both
        {1'b1, 4'd7,  12'h112, 8'h00, 8'h03}, // R7 sel 3 reads A
        {1'b0, 4'd6,  12'h008, 8'h02, 8'h00},
        {1'b1, 4'd4,  12'h112, 8'h00, 8'h03}, // R4 B also got it
        {1'b0, 4'd3,  12'h112, 8'h05, 8'h00}, // R3 B only
        {1'b1, 4'd3,  12'h112, 8'h00, 8'h05},
        {1'b1, 4'd8,  12'h030, 8'h00, 8'h01}, // R8 code 5 unsupported
        {1'b0, 4'd6,  12'h008, 8'h01, 8'h00},
        {1'b1, 4'd3,  12'h112, 8'h00, 8'h03}, // R3 A untouched
        {1'b1, 4'd8,  12'h030, 8'h00, 8'h00}, // R8 code 3 supported
        {1'b0, 4'd2,  12'h110, 8'hFF, 8'h00}, // R2 A only
        {1'b1, 4'd10, 12'h110, 8'h00, 8'h80}, // R10 only bit 7
        {1'b0, 4'd6,  12'h008, 8'h02, 8'h00},
        {1'b1, 4'd2,  12'h110, 8'h00, 8'h00}, // R2 B untouched
        {1'b0, 4'd6,  12'h008, 8'h00, 8'h00}, // R6 select 0
        {1'b1, 4'd6,  12'h008, 8'h00, 8'h00},
        {1'b1, 4'd5,  12'h112, 8'h00, 8'h00}, // R5 paged read 0
        {1'b1, 4'd5,  12'h030, 8'h00, 8'h00}, // R5 status read 0
        {1'b0, 4'd5,  12'h112, 8'h07, 8'h00}, // R5 ignored
        {1'b0, 4'd5,  12'h110, 8'h80, 8'h00}, // R5 ignored
        {1'b0, 4'd6,  12'h008, 8'h02, 8'h00}, // R6 writable from 0
        {1'b1, 4'd5,  12'h112, 8'h00, 8'h05}, // R5 B kept 5
        {1'b1, 4'd5,  12'h110, 8'h00, 8'h00}, // R5 B fmt kept 0
        {1'b0, 4'd6,  12'h008, 8'h01, 8'h00},
        {1'b1, 4'd5,  12'h112, 8'h00, 8'h03}, // R5 A kept 3
        {1'b0, 4'd6,  12'h008, 8'hFE, 8'h00}, // R6 upper bits dropped
        {1'b1, 4'd6,  12'h008, 8'h00, 8'h02},
        {1'b1, 4'd10, 12'h200, 8'h00, 8'h00}, // R10 unmapped
        {1'b0, 4'd10, 12'h200, 8'hAA, 8'h00},
        {1'b1, 4'd10, 12'h200, 8'h00, 8'h00},
        {1'b1, 4'd7,  12'h112, 8'h00, 8'h05}  // R7 sel 2 reads B
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 a_mode", {5'b0, a_interp_mode}, 8'h00);
        check("R1 b_mode", {5'b0, b_interp_mode}, 8'h00);
        check("R1 fmts", {6'b0, a_fmt_offset, b_fmt_offset}, 8'h00);

        for (int i = 0; i < N; i++) begin
            if (TBL[i][32]) begin
                do_read(TBL[i][27:16], rd);
                check($sformatf("R%0d vec%0d", TBL[i][31:28], i), rd, TBL[i][7:0]);
            end else begin
                do_write(TBL[i][27:16], TBL[i][15:8]);
            end
        end

        // R2 R3 field ports
        check("R2 a_fmt port", {7'b0, a_fmt_offset}, 8'h01);
        check("R3 b_mode port", {5'b0, b_interp_mode}, 8'h05);
        check("R3 a_mode port", {5'b0, a_interp_mode}, 8'h03);
        check("R2 b_fmt port", {7'b0, b_fmt_offset}, 8'h00);

        // R9 same-cycle read and write returns old value (select is 2, B holds 5)
        @(negedge clk);
        bus_addr = 12'h112; bus_wdata = 8'h04; bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        check("R9 read-before-write", bus_rdata, 8'h05);
        do_read(12'h112, rd);
        check("R9 new value", rd, 8'h04);
        // R9 hold while re low
        @(negedge clk);
        bus_addr = 12'h008;
        repeat (2) @(negedge clk);
        check("R9 hold", bus_rdata, 8'h04);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 a_fmt after reset", {7'b0, a_fmt_offset}, 8'h00);
        check("R1 b_mode after reset", {5'b0, b_interp_mode}, 8'h00);
        do_read(12'h008, rd);
        check("R1 select after reset", rd, 8'h03);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule